// File: doc/BRIEF.md
# External Bus Bank Controller

This block connects a single-transfer internal request port to as many as four external memory or peripheral devices that share one address bus and one data bus. A request address inside the bank region selects one of four 64 MB banks. The controller then asserts that bank's chip-select line and runs a read or write cycle on the shared bus. The cycle has a setup phase, then a strobe phase, then a one-cycle response. Each bank has its own configuration inputs: enable, data width, phase lengths, chip-select and strobe polarity, and ready handling.

A slow device can stretch the strobe phase through an asynchronous ready line. The controller synchronizes this line and compares it against a per-bank wait level. A watchdog counter measures how long the cycle is stretched. When the limit is reached, the cycle is aborted, the request gets an error response, and a sticky interrupt flag is set. A single control input turns the watchdog off, and the cycle then waits on the ready line without limit. A request outside the bank region, or to a disabled bank, is answered with an error at once and never touches the bus.

Top module: `ebus_bank_ctrl`

## Requirements
- R1: A request whose address bits [31:28] equal 4'h6 addresses bank = address[27:26]. During its cycle only that bank's chip select is at its active level, and the other three stay inactive.
- R2: A request outside the region, or to a bank whose `cfg_bank_en` bit is 0, gets `req_ready` after one clock edge with `rsp_err`=1 and `rsp_rdata`=0. No chip select is asserted.
- R3: Chip select pin i is active-high when `cfg_cs_pol[i]`=1 and active-low otherwise. The read and write strobes of the addressed bank follow that bank's `cfg_str_pol` bit in the same way.
- R4: Each bank's 2-bit setup value S and strobe value T set the cycle. The chip select is active for S+T+2 cycles, and a strobe is active for the last T+1 of them. `req_ready` is high for exactly one cycle, S+T+3 clock edges after the request is accepted.
- R5: When a bank's `cfg_wide` bit is 0 it is 8 bits wide. Writes drive `ext_dout[15:8]`=0, and reads return `ext_din[7:0]` zero-extended. A 16-bit bank uses all 16 bits. A write response carries `rsp_rdata`=0.
- R6: When `cfg_rdy_en` is set for the bank, the strobe phase is held while the line, after a two-flop synchronizer, sits at the wait level. The wait level is high when `cfg_rdy_lo`=1 and low when `cfg_rdy_lo`=0. When `cfg_rdy_en` is clear, the line has no effect.
- R7: If the wait lasts TMO_CYC cycles (default 32), the cycle is aborted. The response comes S+T+3+TMO_CYC edges after acceptance, with `rsp_err`=1 and `rsp_rdata`=0, and `tmo_irq` is set.
- R8: With `cfg_tmo_dis`=1 no abort happens, and the cycle completes normally without error once the wait ends.
- R9: `tmo_irq` stays set until an `irq_clr` pulse. It reads 0 one cycle after that pulse, and an error-free access does not clear it.
- R10: During the strobe, `ext_addr` equals request address [25:0]. `ext_doe` is 1 with write data on `ext_dout` only in write cycles.
- R11: Out of reset, all chip selects and strobes are inactive, and `req_ready` and `tmo_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | EDW | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error response, valid with `req_ready` |
| rsp_rdata | output | EDW | Read data, valid with `req_ready` |
| cfg_bank_en | input | 4 | Per-bank enable |
| cfg_wide | input | 4 | Per-bank width: 1 = 16-bit, 0 = 8-bit |
| cfg_cs_pol | input | 4 | Per-bank chip-select polarity: 1 = active high |
| cfg_str_pol | input | 4 | Per-bank strobe polarity: 1 = active high |
| cfg_rdy_en | input | 4 | Per-bank ready-wait enable |
| cfg_rdy_lo | input | 4 | Per-bank wait level: 1 = wait while line high |
| cfg_setup | input | 4*TW | Per-bank setup length, bank i at [i*TW +: TW] |
| cfg_strobe | input | 4*TW | Per-bank strobe length, bank i at [i*TW +: TW] |
| cfg_tmo_dis | input | 1 | Disables the wait watchdog |
| irq_clr | input | 1 | Clears `tmo_irq` |
| tmo_irq | output | 1 | Sticky timeout interrupt |
| ext_cs | output | 4 | Chip-select pins |
| ext_oe | output | 1 | Read strobe pin |
| ext_we | output | 1 | Write strobe pin |
| ext_addr | output | 26 | External address |
| ext_dout | output | EDW | External write data |
| ext_doe | output | 1 | External data output enable |
| ext_din | input | EDW | External read data |
| ext_rdy | input | 1 | Asynchronous ready line |

## Verification
The bench builds the block with EDW=16, TW=2 and TMO_CYC=8. The 2-bit phase fields let it sweep every setup and strobe length on every bank, for both reads and writes, while the polarity and width settings change from one access to the next. The shortened watchdog makes the exact abort cycle cheap to reach for both wait polarities. It also leaves room for an unlimited wait with the watchdog off that lasts well past the limit.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int NBANK = 4;
  localparam int BSEL_W = 2;
  localparam logic [3:0] REGION_TAG = 4'h6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_RESP
  } ebus_st_e;
endpackage

// File: rtl/ebus_decode.sv
module ebus_decode
  import ebus_pkg::*;
(
  input  logic [31:0]       addr,
  input  logic [NBANK-1:0]  bank_en,
  output logic              hit,
  output logic [BSEL_W-1:0] bank
);
  always_comb begin
    bank = addr[27:26];
    hit  = (addr[31:28] == REGION_TAG) && bank_en[bank];
  end
endmodule

// File: rtl/ebus_sync.sv
module ebus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int EDW     = 16,
  parameter int TW      = 2,
  parameter int TMO_CYC = 32,
  parameter int XAW     = 26
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [XAW-1:0]      req_addr,
  input  logic [EDW-1:0]      req_wdata,
  input  logic                dec_hit,
  input  logic [BSEL_W-1:0]   dec_bank,
  input  logic [NBANK-1:0]    cfg_wide,
  input  logic [NBANK-1:0]    cfg_rdy_en,
  input  logic [NBANK-1:0]    cfg_rdy_lo,
  input  logic [NBANK*TW-1:0] cfg_setup,
  input  logic [NBANK*TW-1:0] cfg_strobe,
  input  logic                cfg_tmo_dis,
  input  logic                rdy_s,
  input  logic                irq_clr,
  input  logic [EDW-1:0]      ext_din,
  output logic                req_ready,
  output logic                rsp_err,
  output logic [EDW-1:0]      rsp_rdata,
  output logic [NBANK-1:0]    cs_act,
  output logic                oe_act,
  output logic                we_act,
  output logic [BSEL_W-1:0]   bank_sel,
  output logic [XAW-1:0]      ext_addr,
  output logic [EDW-1:0]      ext_dout,
  output logic                ext_doe,
  output logic                tmo_irq
);
  localparam int LW  = EDW / 2;
  localparam int TCW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [TCW-1:0] TC_LAST = TCW'(TMO_CYC - 1);

  ebus_st_e          st_q, st_d;
  logic [TW-1:0]     cnt_q, cnt_d;
  logic [TCW-1:0]    tcnt_q, tcnt_d;
  logic [BSEL_W-1:0] bank_q;
  logic              we_q;
  logic [XAW-1:0]    addr_q;
  logic [EDW-1:0]    wdata_q;
  logic              err_q, err_d;
  logic [EDW-1:0]    rdata_q, rdata_d;
  logic              irq_q, irq_d, irq_set;
  logic              ld_req, busy, wait_now, wide;
  logic [TW-1:0]     sel_setup, sel_strobe;
  logic [EDW-1:0]    din_fmt, dout_fmt;

  assign ld_req     = (st_q == ST_IDLE) && req_valid && dec_hit;
  assign sel_setup  = cfg_setup[bank_q*TW +: TW];
  assign sel_strobe = cfg_strobe[bank_q*TW +: TW];
  assign wide       = cfg_wide[bank_q];
  assign wait_now   = cfg_rdy_en[bank_q] && (rdy_s == cfg_rdy_lo[bank_q]);
  assign din_fmt    = wide ? ext_din : {{(EDW-LW){1'b0}}, ext_din[LW-1:0]};
  assign dout_fmt   = wide ? wdata_q : {{(EDW-LW){1'b0}}, wdata_q[LW-1:0]};

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    tcnt_d  = tcnt_q;
    err_d   = err_q;
    rdata_d = rdata_q;
    irq_set = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (dec_hit) begin
            st_d  = ST_SETUP;
            cnt_d = '0;
          end else begin
            st_d    = ST_RESP;
            err_d   = 1'b1;
            rdata_d = '0;
          end
        end
      end
      ST_SETUP: begin
        if (cnt_q == sel_setup) begin
          st_d  = ST_STROBE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt_q == sel_strobe) begin
          if (wait_now) begin
            st_d   = ST_WAIT;
            tcnt_d = '0;
          end else begin
            st_d    = ST_RESP;
            err_d   = 1'b0;
            rdata_d = we_q ? '0 : din_fmt;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (!wait_now) begin
          st_d    = ST_RESP;
          err_d   = 1'b0;
          rdata_d = we_q ? '0 : din_fmt;
        end else if (!cfg_tmo_dis && (tcnt_q == TC_LAST)) begin
          st_d    = ST_RESP;
          err_d   = 1'b1;
          rdata_d = '0;
          irq_set = 1'b1;
        end else if (!cfg_tmo_dis) begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    irq_d = irq_set | (irq_q & ~irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      tcnt_q  <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
      bank_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      tcnt_q  <= tcnt_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
      irq_q   <= irq_d;
      if (ld_req) begin
        bank_q  <= dec_bank;
        we_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign busy      = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_WAIT);
  assign cs_act    = busy ? (NBANK'(1) << bank_q) : '0;
  assign oe_act    = ((st_q == ST_STROBE) || (st_q == ST_WAIT)) && !we_q;
  assign we_act    = ((st_q == ST_STROBE) || (st_q == ST_WAIT)) && we_q;
  assign ext_doe   = busy && we_q;
  assign ext_dout  = ext_doe ? dout_fmt : '0;
  assign ext_addr  = busy ? addr_q : '0;
  assign bank_sel  = bank_q;
  assign req_ready = (st_q == ST_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign tmo_irq   = irq_q;

  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_act));

  p_bad_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req_valid && !dec_hit)
      |=> (req_ready && rsp_err && rsp_rdata == '0 && cs_act == '0));

  p_ready_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  p_tcnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (tcnt_q <= TC_LAST));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && wait_now && !cfg_tmo_dis && tcnt_q == TC_LAST)
      |=> (tmo_irq && req_ready && rsp_err && rsp_rdata == '0));

  p_no_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && wait_now && cfg_tmo_dis) |=> (st_q == ST_WAIT));

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_irq && !irq_clr) |=> tmo_irq);
endmodule

// File: rtl/ebus_bank_ctrl.sv
module ebus_bank_ctrl
  import ebus_pkg::*;
#(
  parameter int EDW     = 16,
  parameter int TW      = 2,
  parameter int TMO_CYC = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [31:0]         req_addr,
  input  logic [EDW-1:0]      req_wdata,
  output logic                req_ready,
  output logic                rsp_err,
  output logic [EDW-1:0]      rsp_rdata,
  input  logic [NBANK-1:0]    cfg_bank_en,
  input  logic [NBANK-1:0]    cfg_wide,
  input  logic [NBANK-1:0]    cfg_cs_pol,
  input  logic [NBANK-1:0]    cfg_str_pol,
  input  logic [NBANK-1:0]    cfg_rdy_en,
  input  logic [NBANK-1:0]    cfg_rdy_lo,
  input  logic [NBANK*TW-1:0] cfg_setup,
  input  logic [NBANK*TW-1:0] cfg_strobe,
  input  logic                cfg_tmo_dis,
  input  logic                irq_clr,
  output logic                tmo_irq,
  output logic [NBANK-1:0]    ext_cs,
  output logic                ext_oe,
  output logic                ext_we,
  output logic [25:0]         ext_addr,
  output logic [EDW-1:0]      ext_dout,
  output logic                ext_doe,
  input  logic [EDW-1:0]      ext_din,
  input  logic                ext_rdy
);
  localparam int XAW = 26;

  logic              dec_hit;
  logic [BSEL_W-1:0] dec_bank;
  logic              rdy_s;
  logic [NBANK-1:0]  cs_act;
  logic              oe_act, we_act;
  logic [BSEL_W-1:0] bank_sel;

  ebus_decode u_dec (
    .addr    (req_addr),
    .bank_en (cfg_bank_en),
    .hit     (dec_hit),
    .bank    (dec_bank)
  );

  ebus_sync u_rdy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_rdy),
    .q     (rdy_s)
  );

  ebus_seq #(
    .EDW     (EDW),
    .TW      (TW),
    .TMO_CYC (TMO_CYC),
    .XAW     (XAW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr[XAW-1:0]),
    .req_wdata   (req_wdata),
    .dec_hit     (dec_hit),
    .dec_bank    (dec_bank),
    .cfg_wide    (cfg_wide),
    .cfg_rdy_en  (cfg_rdy_en),
    .cfg_rdy_lo  (cfg_rdy_lo),
    .cfg_setup   (cfg_setup),
    .cfg_strobe  (cfg_strobe),
    .cfg_tmo_dis (cfg_tmo_dis),
    .rdy_s       (rdy_s),
    .irq_clr     (irq_clr),
    .ext_din     (ext_din),
    .req_ready   (req_ready),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .cs_act      (cs_act),
    .oe_act      (oe_act),
    .we_act      (we_act),
    .bank_sel    (bank_sel),
    .ext_addr    (ext_addr),
    .ext_dout    (ext_dout),
    .ext_doe     (ext_doe),
    .tmo_irq     (tmo_irq)
  );

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_cs_pin
    assign ext_cs[gi] = cfg_cs_pol[gi] ? cs_act[gi] : ~cs_act[gi];
  end

  assign ext_oe = cfg_str_pol[bank_sel] ? oe_act : ~oe_act;
  assign ext_we = cfg_str_pol[bank_sel] ? we_act : ~we_act;

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_act && we_act));

  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_act || we_act) |-> (cs_act != '0));
endmodule

// File: tb/ebus_bank_ctrl_bench.sv
module ebus_bank_ctrl_bench;
  localparam int EDW = 16;
  localparam int TW = 2;
  localparam int TMO = 8;

  logic clk, rst_n;
  logic req_valid, req_write, req_ready, rsp_err;
  logic [31:0] req_addr;
  logic [EDW-1:0] req_wdata, rsp_rdata, ext_dout, ext_din;
  logic [3:0] cfg_bank_en, cfg_wide, cfg_cs_pol, cfg_str_pol, cfg_rdy_en, cfg_rdy_lo;
  logic [4*TW-1:0] cfg_setup, cfg_strobe;
  logic cfg_tmo_dis, irq_clr, tmo_irq, ext_oe, ext_we, ext_doe, ext_rdy;
  logic [3:0] ext_cs;
  logic [25:0] ext_addr;

  int n_total, n_fail;
  int n_edges, n_cs, n_stb, n_bad;
  logic got_err;
  logic [EDW-1:0] got_data;

  ebus_bank_ctrl #(.EDW(EDW), .TW(TW), .TMO_CYC(TMO)) u_ebus_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cfg_bank_en(cfg_bank_en),
    .cfg_wide(cfg_wide), .cfg_cs_pol(cfg_cs_pol), .cfg_str_pol(cfg_str_pol),
    .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_lo(cfg_rdy_lo), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .cfg_tmo_dis(cfg_tmo_dis), .irq_clr(irq_clr),
    .tmo_irq(tmo_irq), .ext_cs(ext_cs), .ext_oe(ext_oe), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_din(ext_din), .ext_rdy(ext_rdy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  // bank b > 3 means no chip select may ever become active
  task automatic run_acc(input logic [31:0] a, input logic w, input logic [15:0] wd, input int b);
    logic [15:0] exp_dout;
    bit done;
    exp_dout = (b < 4 && cfg_wide[b]) ? wd : {8'h00, wd[7:0]};
    n_edges = 0; n_cs = 0; n_stb = 0; n_bad = 0; done = 0;
    @(negedge clk);
    req_addr = a; req_write = w; req_wdata = wd; req_valid = 1'b1;
    while (!done && n_edges < 300) begin
      @(posedge clk);
      @(negedge clk);
      n_edges++;
      for (int i = 0; i < 4; i++) begin
        if (ext_cs[i] == cfg_cs_pol[i]) begin
          if (i == b) n_cs++;
          else n_bad++;
        end
      end
      if (b < 4) begin
        logic oe_a, we_a;
        oe_a = (ext_oe == cfg_str_pol[b]);
        we_a = (ext_we == cfg_str_pol[b]);
        if (oe_a || we_a) begin
          n_stb++;
          if (w ? (!we_a || oe_a) : (!oe_a || we_a)) n_bad++;
          if (ext_addr != a[25:0]) n_bad++;
          if (w && (!ext_doe || ext_dout != exp_dout)) n_bad++;
          if (!w && ext_doe) n_bad++;
        end
      end
      if (req_ready) done = 1;
    end
    got_err = rsp_err;
    got_data = rsp_rdata;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    n_total = 0; n_fail = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_bank_en = 4'hF; cfg_wide = 4'hF; cfg_cs_pol = 4'b0101; cfg_str_pol = 4'h0;
    cfg_rdy_en = 4'h0; cfg_rdy_lo = 4'hF; cfg_setup = '0; cfg_strobe = '0;
    cfg_tmo_dis = 1'b0; irq_clr = 1'b0; ext_din = 16'h0; ext_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ext_cs == ~cfg_cs_pol, "R11 chip selects idle", ext_cs, ~cfg_cs_pol);
    chk(ext_oe == 1'b1 && ext_we == 1'b1, "R11 strobes idle", {ext_oe, ext_we}, 2'b11);
    chk(req_ready == 1'b0, "R11 ready low", req_ready, 0);
    chk(tmo_irq == 1'b0, "R11 irq low", tmo_irq, 0);

    // R1 R3 R4 R5 R10 sweep over bank, setup, strobe, direction
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 4; t++)
          for (int w = 0; w < 2; w++) begin
            logic [31:0] a;
            logic [15:0] wd, din, exp_rd;
            cfg_setup = {4{s[1:0]}};
            cfg_strobe = {4{t[1:0]}};
            cfg_cs_pol = 4'(s * 5 + t + w);
            cfg_str_pol = ((b + s + w) % 2 == 1) ? 4'hF : 4'h0;
            cfg_wide = 4'(4'b1010 ^ {4{t[0]}});
            a = 32'h6000_0000 | (32'(b) << 26) | 32'((s * 977 + t * 31 + w * 4099) * 4);
            wd = 16'(16'hC3A5 + b * 4096 + s * 256 + t * 16 + w);
            din = 16'(16'h5A96 ^ (b * 4369 + s * 257 + t * 17 + w));
            ext_din = din;
            exp_rd = w[0] ? 16'h0 : (cfg_wide[b] ? din : {8'h00, din[7:0]});
            run_acc(a, w[0], wd, b);
            chk(n_edges == s + t + 3, "R4 completion edges", n_edges, s + t + 3);
            chk(n_cs == s + t + 2, "R1 R4 chip select cycles", n_cs, s + t + 2);
            chk(n_stb == t + 1, "R4 strobe cycles", n_stb, t + 1);
            chk(n_bad == 0, "R1 R3 R10 bus pins", n_bad, 0);
            chk(got_err == 1'b0, "R4 no error", got_err, 0);
            chk(got_data == exp_rd, "R5 read data", got_data, exp_rd);
          end

    // R2 outside region and disabled bank
    cfg_setup = '0; cfg_strobe = '0; cfg_cs_pol = 4'b0011; cfg_str_pol = 4'h0; cfg_wide = 4'hF;
    ext_din = 16'hBEEF;
    run_acc(32'h7000_0010, 1'b0, 16'h1234, 4);
    chk(n_edges == 1, "R2 outside region latency", n_edges, 1);
    chk(got_err == 1'b1 && got_data == 16'h0, "R2 outside region error", {got_err, got_data}, 17'h10000);
    chk(n_bad == 0, "R2 outside region no cs", n_bad, 0);
    cfg_bank_en = 4'b1101;
    run_acc(32'h6400_0020, 1'b1, 16'h4321, 4);
    chk(n_edges == 1, "R2 disabled bank latency", n_edges, 1);
    chk(got_err == 1'b1 && got_data == 16'h0, "R2 disabled bank error", {got_err, got_data}, 17'h10000);
    chk(n_bad == 0, "R2 disabled bank no cs", n_bad, 0);
    cfg_bank_en = 4'hF;

    // R6 ready handling on bank 2, wait level high
    cfg_rdy_en = 4'b0100; cfg_rdy_lo = 4'b0100; ext_din = 16'h2468;
    ext_rdy = 1'b0; repeat (3) @(negedge clk);
    run_acc(32'h6800_0004, 1'b0, 16'h0, 2);
    chk(n_edges == 3 && !got_err, "R6 line low no wait", n_edges, 3);

    // R7 abort with wait level high
    ext_rdy = 1'b1; repeat (3) @(negedge clk);
    run_acc(32'h6800_0004, 1'b0, 16'h0, 2);
    chk(n_edges == 3 + TMO, "R7 abort edges", n_edges, 3 + TMO);
    chk(got_err == 1'b1 && got_data == 16'h0, "R7 abort response", {got_err, got_data}, 17'h10000);
    chk(tmo_irq == 1'b1, "R7 irq set", tmo_irq, 1);

    // R9 sticky across an error-free access
    ext_rdy = 1'b0; repeat (3) @(negedge clk);
    run_acc(32'h6800_0008, 1'b0, 16'h0, 2);
    chk(got_err == 1'b0 && got_data == 16'h2468, "R6 normal after release", got_data, 16'h2468);
    chk(tmo_irq == 1'b1, "R9 irq sticky", tmo_irq, 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(tmo_irq == 1'b0, "R9 irq cleared", tmo_irq, 0);

    // R6 polarity: wait level low
    cfg_rdy_lo = 4'b0000;
    ext_rdy = 1'b0; repeat (3) @(negedge clk);
    run_acc(32'h6800_000C, 1'b1, 16'h55AA, 2);
    chk(n_edges == 3 + TMO && got_err, "R6 R7 low wait level aborts", n_edges, 3 + TMO);
    ext_rdy = 1'b1; repeat (3) @(negedge clk);
    run_acc(32'h6800_000C, 1'b1, 16'h55AA, 2);
    chk(n_edges == 3 && !got_err, "R6 high line no wait", n_edges, 3);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;

    // R6 ready disabled: wait level ignored
    cfg_rdy_en = 4'b0000; ext_rdy = 1'b0; repeat (3) @(negedge clk);
    run_acc(32'h6800_0010, 1'b0, 16'h0, 2);
    chk(n_edges == 3 && !got_err, "R6 ready disabled ignored", n_edges, 3);

    // R8 watchdog off: long wait then release
    cfg_rdy_en = 4'b0100; cfg_tmo_dis = 1'b1; ext_din = 16'h1357;
    ext_rdy = 1'b0; repeat (3) @(negedge clk);
    fork
      run_acc(32'h6800_0014, 1'b0, 16'h0, 2);
      begin
        repeat (30) @(negedge clk);
        ext_rdy = 1'b1;
      end
    join
    chk(n_edges >= 29 && n_edges <= 40, "R8 long wait edges", n_edges, 32);
    chk(got_err == 1'b0 && got_data == 16'h1357, "R8 completes without error", {got_err, got_data}, 17'h01357);
    chk(tmo_irq == 1'b0, "R8 no irq", tmo_irq, 0);

    finish_run();
  end
endmodule